// File: doc/BRIEF.md
# Video Row Streamer with Random-Access Port

This block models a dual-ported frame memory. One side is an ordinary random-access port: a client reads or writes one data item per cycle. The other side is a serial output that can only be read and is meant to feed a display. To use the serial side, the client issues a row transfer naming one row of the array. On the next clock edge the whole row is copied at once into an internal shift register.

After that, each pulse of the shift-clock enable moves the next item of the copied row onto the serial output, from the lowest column to the highest. A line-end flag marks the last item of the row. While the row streams out, the random-access port stays fully usable for drawing. The copied row is a snapshot, so later writes to the array never reach it.

A transfer and a random-access request in the same cycle conflict. The transfer wins. The random-access request is refused for that cycle through a stall output, and the client presents it again on the next cycle.

Top module: `vidRowStreamer`

## Requirements
- R1: After reset, `serData` is 0, `serLineEnd` is 0 and `raRvalid` is 0. Shift pulses given before any transfer keep presenting 0.
- R2: The random-access address is `{row, column}`, with the column in the low `$clog2(ROW_ITEMS)` bits.
  - With `raReq=1` and `raWe=1`, `raWdata` is written to that item.
  - With `raReq=1` and `raWe=0`, the item is returned on `raRdata` with `raRvalid=1` one cycle after the request.
  - When no transfer is requested in that cycle, `raStall` is 0.
- R3: A cycle with `xferReq=1` copies row `xferRow` into the shift register. The following `sclkEn` pulses present columns 0, 1, 2 and so on of that row on `serData`. Each item appears in the cycle after its pulse.
- R4: `serLineEnd` is 1 exactly while the last column of the row is on `serData`. It is 0 for every earlier item, and it is cleared by a transfer.
- R5: Once the last column has been presented, further `sclkEn` pulses keep `serData` at that item and `serLineEnd` at 1, until the next transfer.
- R6: When `xferReq` and `raReq` are both 1 in a cycle:
  - `raStall` is 1 in that cycle.
  - The random-access operation is not performed: no write takes effect and no `raRvalid` follows.
  - The transfer proceeds.
- R7: A write to the array after a transfer does not change the items already copied into the shift register, even when it targets the transferred row.
- R8: Random-access reads and writes performed in the same cycles as `sclkEn` pulses both complete correctly. Neither disturbs the other.
- R9: Without an `sclkEn` pulse, `serData` holds its value. An `sclkEn` pulse in a transfer cycle is ignored, and the first pulse after the transfer still presents column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| raReq | input | 1 | Random-access request |
| raWe | input | 1 | 1 = write, 0 = read |
| raAddr | input | ROW_AW+COL_AW | Item address {row, column} |
| raWdata | input | DATA_W | Write data |
| raRdata | output | DATA_W | Read data |
| raRvalid | output | 1 | Read data valid, one cycle after an accepted read |
| raStall | output | 1 | Request refused this cycle because a transfer has priority |
| xferReq | input | 1 | Row transfer request |
| xferRow | input | ROW_AW | Row to copy into the shift register |
| sclkEn | input | 1 | Shift-clock pulse, one cycle per item |
| serData | output | DATA_W | Serial output item |
| serLineEnd | output | 1 | Last item of the row is on serData |

## Verification
The bench builds the block with 8-bit items, 16 items per row and 4 rows. With a short row, a full stream, the line-end item and the repeat after saturation are all reached in a few dozen cycles. The 64-item array is also small enough to be filled completely and checked against a model in the bench. Four rows leave room to transfer one row while writes go to another, and to overwrite the transferred row during its stream.

// File: rtl/vidRowStreamerPkg.sv
package vidRowStreamerPkg;
  typedef struct packed {
    logic doXfer;    // copy selected row into shift buffer
    logic doWrite;   // perform random-access write
    logic doRead;    // perform random-access read
    logic doShift;   // present next item on serial output
    logic markLast;  // the item being presented is the last of the row
  } strobeT;
endpackage

// File: rtl/vidRowStreamerCtrl.sv
module vidRowStreamerCtrl
  import vidRowStreamerPkg::*;
#(
  parameter int ROW_ITEMS = 64
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   raReq,
  input  logic   raWe,
  input  logic   xferReq,
  input  logic   sclkEn,
  output logic   raStall,
  output strobeT strobes
);
  localparam int CNT_W = $clog2(ROW_ITEMS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ROW_ITEMS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROW_ITEMS - 1);

  // number of items of the current row already presented
  logic [CNT_W-1:0] shownCnt;

  always_comb begin
    raStall          = raReq & xferReq;
    strobes.doXfer   = xferReq;
    strobes.doWrite  = raReq & raWe & ~xferReq;
    strobes.doRead   = raReq & ~raWe & ~xferReq;
    strobes.doShift  = sclkEn & ~xferReq & (shownCnt != FULL);
    strobes.markLast = (shownCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shownCnt <= FULL;
    end else if (xferReq) begin
      shownCnt <= '0;
    end else if (strobes.doShift) begin
      shownCnt <= shownCnt + 1'b1;
    end
  end
endmodule

// File: rtl/vidRowStreamerData.sv
module vidRowStreamerData
  import vidRowStreamerPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ROW_ITEMS = 64,
  parameter int ROWS      = 16,
  localparam int COL_AW   = $clog2(ROW_ITEMS),
  localparam int ROW_AW   = $clog2(ROWS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   strobes,
  input  logic [ROW_AW+COL_AW-1:0] raAddr,
  input  logic [DATA_W-1:0]        raWdata,
  input  logic [ROW_AW-1:0]        xferRow,
  output logic [DATA_W-1:0]        raRdata,
  output logic                     raRvalid,
  output logic [DATA_W-1:0]        serData,
  output logic                     serLineEnd
);
  localparam int ROW_BITS = ROW_ITEMS * DATA_W;

  // each array entry is one full row, so a transfer is a single wide read
  logic [ROW_BITS-1:0] rowArr [ROWS];
  logic [ROW_BITS-1:0] shiftBuf;

  logic [ROW_AW-1:0] rowIdx;
  logic [COL_AW-1:0] colIdx;

  assign rowIdx = raAddr[ROW_AW+COL_AW-1:COL_AW];
  assign colIdx = raAddr[COL_AW-1:0];

  always_ff @(posedge clk) begin
    if (strobes.doWrite) begin
      rowArr[rowIdx][colIdx*DATA_W +: DATA_W] <= raWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      raRdata  <= '0;
      raRvalid <= 1'b0;
    end else begin
      raRvalid <= strobes.doRead;
      if (strobes.doRead) begin
        raRdata <= rowArr[rowIdx][colIdx*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftBuf   <= '0;
      serData    <= '0;
      serLineEnd <= 1'b0;
    end else if (strobes.doXfer) begin
      shiftBuf   <= rowArr[xferRow];
      serLineEnd <= 1'b0;
    end else if (strobes.doShift) begin
      serData    <= shiftBuf[DATA_W-1:0];
      shiftBuf   <= shiftBuf >> DATA_W;
      serLineEnd <= strobes.markLast;
    end
  end
endmodule

// File: rtl/vidRowStreamer.sv
module vidRowStreamer
  import vidRowStreamerPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ROW_ITEMS = 64,
  parameter int ROWS      = 16,
  localparam int COL_AW   = $clog2(ROW_ITEMS),
  localparam int ROW_AW   = $clog2(ROWS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     raReq,
  input  logic                     raWe,
  input  logic [ROW_AW+COL_AW-1:0] raAddr,
  input  logic [DATA_W-1:0]        raWdata,
  output logic [DATA_W-1:0]        raRdata,
  output logic                     raRvalid,
  output logic                     raStall,
  input  logic                     xferReq,
  input  logic [ROW_AW-1:0]        xferRow,
  input  logic                     sclkEn,
  output logic [DATA_W-1:0]        serData,
  output logic                     serLineEnd
);
  strobeT strobes;

  vidRowStreamerCtrl #(.ROW_ITEMS(ROW_ITEMS)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .raReq   (raReq),
    .raWe    (raWe),
    .xferReq (xferReq),
    .sclkEn  (sclkEn),
    .raStall (raStall),
    .strobes (strobes)
  );

  vidRowStreamerData #(
    .DATA_W    (DATA_W),
    .ROW_ITEMS (ROW_ITEMS),
    .ROWS      (ROWS)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .raAddr     (raAddr),
    .raWdata    (raWdata),
    .xferRow    (xferRow),
    .raRdata    (raRdata),
    .raRvalid   (raRvalid),
    .serData    (serData),
    .serLineEnd (serLineEnd)
  );
endmodule

// File: rtl/vidRowStreamerChk.sv
module vidRowStreamerChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              raReq,
  input logic              raWe,
  input logic              xferReq,
  input logic              sclkEn,
  input logic              raRvalid,
  input logic [DATA_W-1:0] serData,
  input logic              serLineEnd
);
  // R6: a transfer suppresses the random-access result
  p_xfer_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    raReq && xferReq |=> !raRvalid);

  // R2: an accepted read returns valid data one cycle later
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    raReq && !raWe && !xferReq |=> raRvalid);

  // R9: without a pulse the serial output holds
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !sclkEn |=> $stable(serData));

  // R5: past the line end, pulses repeat the last item
  p_repeat_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    serLineEnd && sclkEn && !xferReq |=> serLineEnd && $stable(serData));

  // R4: a transfer clears the line-end flag
  p_xfer_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |=> !serLineEnd);
endmodule

bind vidRowStreamer vidRowStreamerChk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .raReq      (raReq),
  .raWe       (raWe),
  .xferReq    (xferReq),
  .sclkEn     (sclkEn),
  .raRvalid   (raRvalid),
  .serData    (serData),
  .serLineEnd (serLineEnd)
);

// File: tb/vidRowStreamer_tb_top.sv
`timescale 1ns/1ps
module vidRowStreamer_tb_top;
  localparam int DW    = 8;
  localparam int ITEMS = 16;
  localparam int NROWS = 4;
  localparam int CAW   = $clog2(ITEMS);
  localparam int RAW   = $clog2(NROWS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic raReq = 1'b0, raWe = 1'b0;
  logic [RAW+CAW-1:0] raAddr = '0;
  logic [DW-1:0] raWdata = '0;
  logic [DW-1:0] raRdata;
  logic raRvalid, raStall;
  logic xferReq = 1'b0;
  logic [RAW-1:0] xferRow = '0;
  logic sclkEn = 1'b0;
  logic [DW-1:0] serData;
  logic serLineEnd;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] mdl [NROWS*ITEMS];

  always #4 clk = ~clk;

  vidRowStreamer #(.DATA_W(DW), .ROW_ITEMS(ITEMS), .ROWS(NROWS)) dut_i (
    .clk(clk), .rstN(rstN), .raReq(raReq), .raWe(raWe), .raAddr(raAddr),
    .raWdata(raWdata), .raRdata(raRdata), .raRvalid(raRvalid), .raStall(raStall),
    .xferReq(xferReq), .xferRow(xferRow), .sclkEn(sclkEn),
    .serData(serData), .serLineEnd(serLineEnd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [RAW+CAW-1:0] addrOf(input int row, input int col);
    return {RAW'(row), CAW'(col)};
  endfunction

  task automatic doWrite(input int row, input int col, input logic [DW-1:0] d);
    raReq = 1; raWe = 1; raAddr = addrOf(row, col); raWdata = d;
    @(negedge clk);
    raReq = 0; raWe = 0;
    mdl[row*ITEMS+col] = d;
  endtask

  task automatic doRead(input int row, input int col, output logic [DW-1:0] d, output logic v);
    raReq = 1; raWe = 0; raAddr = addrOf(row, col);
    @(negedge clk);
    raReq = 0;
    d = raRdata; v = raRvalid;
  endtask

  task automatic doXfer(input int row);
    xferReq = 1; xferRow = RAW'(row);
    @(negedge clk);
    xferReq = 0;
  endtask

  task automatic doPulse(output logic [DW-1:0] d, output logic le);
    sclkEn = 1;
    @(negedge clk);
    sclkEn = 0;
    d = serData; le = serLineEnd;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d; logic le;
    check(serData == 0, "R1 serData", serData, 0);
    check(serLineEnd == 0, "R1 serLineEnd", serLineEnd, 0);
    check(raRvalid == 0, "R1 raRvalid", raRvalid, 0);
    doPulse(d, le);
    check(d == 0, "R1 pulse before transfer", d, 0);
  endtask

  task automatic t_fillRead();
    logic [DW-1:0] d; logic v;
    for (int r = 0; r < NROWS; r++)
      for (int c = 0; c < ITEMS; c++)
        doWrite(r, c, DW'(r*37 + c*5 + 1));
    for (int k = 0; k < 6; k++) begin
      int r = (k * 3) % NROWS;
      int c = (k * 7) % ITEMS;
      raReq = 1; raWe = 0; raAddr = addrOf(r, c);
      #1 check(raStall == 0, "R2 no stall", raStall, 0);
      @(negedge clk);
      raReq = 0;
      d = raRdata; v = raRvalid;
      check(v == 1, "R2 rvalid", v, 1);
      check(d == mdl[r*ITEMS+c], "R2 rdata", d, mdl[r*ITEMS+c]);
    end
    @(negedge clk);
    check(raRvalid == 0, "R2 rvalid drops", raRvalid, 0);
  endtask

  task automatic t_stream(input int row);
    logic [DW-1:0] d; logic le;
    doXfer(row);
    check(serLineEnd == 0, "R4 cleared by transfer", serLineEnd, 0);
    for (int k = 0; k < ITEMS; k++) begin
      doPulse(d, le);
      check(d == mdl[row*ITEMS+k], "R3 item order", d, mdl[row*ITEMS+k]);
      check(le == (k == ITEMS-1), "R4 line end", le, (k == ITEMS-1));
    end
  endtask

  task automatic t_repeat(input int row);
    logic [DW-1:0] d; logic le;
    for (int k = 0; k < 3; k++) begin
      doPulse(d, le);
      check(d == mdl[row*ITEMS+ITEMS-1], "R5 repeat last", d, mdl[row*ITEMS+ITEMS-1]);
      check(le == 1, "R5 line end held", le, 1);
    end
  endtask

  task automatic t_hold();
    logic [DW-1:0] d; logic le; logic [DW-1:0] keep;
    keep = serData;
    repeat (3) @(negedge clk);
    check(serData == keep, "R9 hold without pulse", serData, keep);
    xferReq = 1; xferRow = RAW'(2); sclkEn = 1;
    @(negedge clk);
    xferReq = 0; sclkEn = 0;
    check(serData == keep, "R9 pulse in transfer cycle ignored", serData, keep);
    check(serLineEnd == 0, "R9 line end after transfer", serLineEnd, 0);
    doPulse(d, le);
    check(d == mdl[2*ITEMS], "R9 first pulse gives column 0", d, mdl[2*ITEMS]);
  endtask

  task automatic t_conflict();
    logic [DW-1:0] d; logic le; logic v; logic [DW-1:0] old;
    old = mdl[1*ITEMS];
    xferReq = 1; xferRow = RAW'(1);
    raReq = 1; raWe = 1; raAddr = addrOf(1, 0); raWdata = ~old;
    #1 check(raStall == 1, "R6 stall on write conflict", raStall, 1);
    @(negedge clk);
    xferReq = 0; raReq = 0; raWe = 0;
    doPulse(d, le);
    check(d == old, "R6 transfer proceeds with old data", d, old);
    doRead(1, 0, d, v);
    check(d == old, "R6 stalled write not applied", d, old);
    xferReq = 1; xferRow = RAW'(0);
    raReq = 1; raWe = 0; raAddr = addrOf(0, 1);
    #1 check(raStall == 1, "R6 stall on read conflict", raStall, 1);
    @(negedge clk);
    xferReq = 0; raReq = 0;
    check(raRvalid == 0, "R6 no rvalid after conflict", raRvalid, 0);
  endtask

  task automatic t_snapshot();
    logic [DW-1:0] d; logic le;
    logic [DW-1:0] snap [ITEMS];
    for (int c = 0; c < ITEMS; c++) snap[c] = mdl[2*ITEMS+c];
    doXfer(2);
    doWrite(2, 3, ~snap[3]);
    doWrite(2, 0, ~snap[0]);
    for (int k = 0; k < ITEMS; k++) begin
      doPulse(d, le);
      check(d == snap[k], "R7 snapshot unaffected by write", d, snap[k]);
    end
  endtask

  task automatic t_concurrent();
    logic [DW-1:0] d; logic le;
    doXfer(3);
    for (int k = 0; k < ITEMS; k++) begin
      logic [DW-1:0] exp;
      exp = mdl[0*ITEMS+k];
      sclkEn = 1; raReq = 1; raAddr = addrOf(0, k);
      raWe = (k % 2 == 1); raWdata = DW'(8'h50 + k);
      @(negedge clk);
      sclkEn = 0; raReq = 0; raWe = 0;
      d = serData; le = serLineEnd;
      check(d == mdl[3*ITEMS+k], "R8 stream during random access", d, mdl[3*ITEMS+k]);
      if (k % 2 == 0) begin
        check(raRvalid == 1 && raRdata == exp, "R8 read during stream", raRdata, exp);
      end else begin
        mdl[k] = DW'(8'h50 + k);
      end
    end
    for (int k = 1; k < ITEMS; k += 2) begin
      logic v;
      doRead(0, k, d, v);
      check(d == mdl[k], "R8 write during stream landed", d, mdl[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_fillRead();
    t_stream(1);
    t_repeat(1);
    t_hold();
    t_conflict();
    t_snapshot();
    t_concurrent();
    t_stream(0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule